// File: doc/BRIEF.md
# Double-Buffered Serial Converter Input Register

This block is the digital front end of a 16-bit digital-to-analog converter that takes its code over a single serial data line. The chip-select pin doubles as the bit clock: on each of its rising edges the level on the data pin is pushed into a shift register, most significant bit first, so a full word takes 16 pulses with the upper byte sent before the lower byte. Two register ranks sit behind the shifter. The first rank follows the shift register while the framing pin is low and holds its value while that pin is high. The second rank drives the parallel code. It follows the first rank while the load pin is low and freezes on the rising edge of the load pin.

Every pin is treated as asynchronous. It passes through a synchroniser into the system clock domain, and pin edges are found by edge detection. A bit counter tracks how many bits have arrived in the current frame. When a word is latched before 16 bits have arrived, the output still takes the current first-rank value and a short-word flag is raised.

Top module: `sdac_input_reg`

## Requirements
- R1: While the synchronous active-high `rst` is sampled high, `dac_code`, `short_word` and the bit count are cleared to zero, and they stay zero after release until a pin event changes them.
- R2: Each rising edge of `cs_bclk` shifts the level of `ser_data` into bit 0 while older bits move one place toward bit 15. After 16 edges the first bit sent sits in bit 15.
- R3: While `frame_hold` is high, the first rank keeps its value whatever is shifted. When `frame_hold` returns low, the first rank takes the whole current shift register.
- R4: While `load_in` is low, `dac_code` follows the first rank, no later than 6 clock cycles after the pin event that changed it.
- R5: While `load_in` is high after its rising edge, `dac_code` does not change, even while bits are shifted in.
- R6: On each rising edge of `load_in`, `dac_code` captures the first rank. `short_word` becomes 1 if fewer than 16 bits were counted in the frame, and 0 otherwise.
- R7: The bit count saturates at 16. It is cleared on each rising edge of `load_in` and on each rising edge of `frame_hold`, so bits sent before either event do not count toward the next word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| ser_data | input | 1 | Serial data, sampled on rising `cs_bclk` |
| cs_bclk | input | 1 | Chip-select pin used as the bit clock |
| frame_hold | input | 1 | High: first rank holds; low: first rank follows the shifter |
| load_in | input | 1 | Low: output rank follows; rising edge: output frozen |
| dac_code | output | 16 | Parallel converter code from the second rank |
| short_word | output | 1 | Set when the last latched word had fewer than 16 bits |

## Verification
The assertions take three things for granted about the inputs. Each pin level lasts longer than the synchroniser depth. `ser_data` is settled before `cs_bclk` rises. A load edge never falls in the same synchronised cycle as a bit edge. The stimulus holds every pin level for at least four system clocks and changes data only while `cs_bclk` is low. It also separates the load and framing steps from the bit pulses, so every edge the design sees is clean and isolated.

// File: rtl/sdac_pkg.sv
`timescale 1ns/1ps
package sdac_pkg;

    localparam int DEF_WORD_W      = 16;
    localparam int DEF_SYNC_STAGES = 2;

    // Raw pin bundle carried through the synchroniser
    typedef struct packed {
        logic data;
        logic bclk;
        logic frame;
        logic load;
    } pins_t;

    // Index of each control pin inside the edge-detector vector
    localparam int EDGE_BCLK  = 0;
    localparam int EDGE_FRAME = 1;
    localparam int EDGE_LOAD  = 2;
    localparam int EDGE_N     = 3;

    // Width needed to count 0..w
    function automatic int cnt_bits(input int w);
        return $clog2(w + 1);
    endfunction

endpackage

// File: rtl/sdac_sync.sv
`timescale 1ns/1ps
module sdac_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    logic [W-1:0] st [STAGES];

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) st[g] <= '0;
                    else     st[g] <= d;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) st[g] <= '0;
                    else     st[g] <= st[g-1];
                end
            end
        end
    endgenerate

    assign q = st[STAGES-1];

endmodule

// File: rtl/sdac_edge.sv
`timescale 1ns/1ps
module sdac_edge #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] lvl,
    output logic [W-1:0] rise
);

    logic [W-1:0] prev_q;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= '0;
        else     prev_q <= lvl;
    end

    assign rise = lvl & ~prev_q;

endmodule

// File: rtl/sdac_rank1.sv
`timescale 1ns/1ps
module sdac_rank1 #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          bit_rise,
    input  logic          bit_val,
    input  logic          hold_lvl,
    input  logic          cnt_clr,
    output logic [W-1:0]  shift_q,
    output logic [W-1:0]  rank1_q,
    output logic [CW-1:0] bit_cnt
);

    localparam logic [CW-1:0] CNT_MAX = CW'(W);

    logic [W-1:0]  shift_d;
    logic [CW-1:0] cnt_base;
    logic [CW-1:0] cnt_d;

    always_comb begin
        shift_d = bit_rise ? {shift_q[W-2:0], bit_val} : shift_q;
        cnt_base = cnt_clr ? '0 : bit_cnt;
        cnt_d = cnt_base;
        if (bit_rise && (cnt_base < CNT_MAX))
            cnt_d = cnt_base + CW'(1);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            shift_q <= '0;
            rank1_q <= '0;
            bit_cnt <= '0;
        end else begin
            shift_q <= shift_d;
            bit_cnt <= cnt_d;
            if (!hold_lvl)
                rank1_q <= shift_d;
        end
    end

endmodule

// File: rtl/sdac_rank2.sv
`timescale 1ns/1ps
module sdac_rank2 #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ld_lvl,
    input  logic          ld_rise,
    input  logic [W-1:0]  rank1_q,
    input  logic [CW-1:0] bit_cnt,
    output logic [W-1:0]  code_q,
    output logic          short_q
);

    localparam logic [CW-1:0] CNT_FULL = CW'(W);

    always_ff @(posedge clk) begin
        if (rst) begin
            code_q  <= '0;
            short_q <= 1'b0;
        end else begin
            if (!ld_lvl || ld_rise)
                code_q <= rank1_q;
            if (ld_rise)
                short_q <= (bit_cnt != CNT_FULL);
        end
    end

endmodule

// File: rtl/sdac_input_reg.sv
`timescale 1ns/1ps
module sdac_input_reg
    import sdac_pkg::*;
#(
    parameter int WORD_W      = DEF_WORD_W,
    parameter int SYNC_STAGES = DEF_SYNC_STAGES
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ser_data,
    input  logic              cs_bclk,
    input  logic              frame_hold,
    input  logic              load_in,
    output logic [WORD_W-1:0] dac_code,
    output logic              short_word
);

    localparam int CW = cnt_bits(WORD_W);

    pins_t              pins_raw;
    pins_t              pins_s;
    logic [EDGE_N-1:0]  ctl_lvl;
    logic [EDGE_N-1:0]  ctl_rise;
    logic               bit_rise;
    logic               ld_rise;
    logic               fr_rise;
    logic [WORD_W-1:0]  shift_q;
    logic [WORD_W-1:0]  rank1_q;
    logic [CW-1:0]      bit_cnt;

    assign pins_raw = '{data: ser_data, bclk: cs_bclk, frame: frame_hold, load: load_in};

    sdac_sync #(.W($bits(pins_t)), .STAGES(SYNC_STAGES)) sync_i (
        .clk (clk),
        .rst (rst),
        .d   (pins_raw),
        .q   (pins_s)
    );

    always_comb begin
        ctl_lvl             = '0;
        ctl_lvl[EDGE_BCLK]  = pins_s.bclk;
        ctl_lvl[EDGE_FRAME] = pins_s.frame;
        ctl_lvl[EDGE_LOAD]  = pins_s.load;
    end

    sdac_edge #(.W(EDGE_N)) edge_i (
        .clk  (clk),
        .rst  (rst),
        .lvl  (ctl_lvl),
        .rise (ctl_rise)
    );

    assign bit_rise = ctl_rise[EDGE_BCLK];
    assign fr_rise  = ctl_rise[EDGE_FRAME];
    assign ld_rise  = ctl_rise[EDGE_LOAD];

    sdac_rank1 #(.W(WORD_W), .CW(CW)) rank1_i (
        .clk      (clk),
        .rst      (rst),
        .bit_rise (bit_rise),
        .bit_val  (pins_s.data),
        .hold_lvl (pins_s.frame),
        .cnt_clr  (ld_rise | fr_rise),
        .shift_q  (shift_q),
        .rank1_q  (rank1_q),
        .bit_cnt  (bit_cnt)
    );

    sdac_rank2 #(.W(WORD_W), .CW(CW)) rank2_i (
        .clk     (clk),
        .rst     (rst),
        .ld_lvl  (pins_s.load),
        .ld_rise (ld_rise),
        .rank1_q (rank1_q),
        .bit_cnt (bit_cnt),
        .code_q  (dac_code),
        .short_q (short_word)
    );

endmodule

// File: rtl/sdac_input_reg_chk.sv
`timescale 1ns/1ps
module sdac_input_reg_chk #(
    parameter int W  = 16,
    parameter int CW = 5
) (
    input logic          clk,
    input logic          rst,
    input logic          bit_rise,
    input logic          bit_val,
    input logic          ld_rise,
    input logic          fr_rise,
    input logic          ld_lvl,
    input logic          hold_lvl,
    input logic [W-1:0]  shift_q,
    input logic [W-1:0]  rank1_q,
    input logic [CW-1:0] bit_cnt,
    input logic [W-1:0]  dac_code,
    input logic          short_word
);

    localparam logic [CW-1:0] FULL = CW'(W);

    // R1: reset clears the output and the flag
    p_reset_clear_r1: assert property (@(posedge clk)
        rst |=> (dac_code == '0) && !short_word && (bit_cnt == '0));

    // R2: a bit edge shifts the sampled bit into position 0
    p_shift_in_r2: assert property (@(posedge clk) disable iff (rst)
        bit_rise |=> shift_q == {$past(shift_q[W-2:0]), $past(bit_val)});

    // R3: first rank is stable while held
    p_rank1_hold_r3: assert property (@(posedge clk) disable iff (rst)
        hold_lvl |=> $stable(rank1_q));

    // R5: output frozen while load stays high
    p_out_frozen_r5: assert property (@(posedge clk) disable iff (rst)
        (ld_lvl && !ld_rise) |=> $stable(dac_code));

    // R6: full word clears the flag, short word sets it
    p_flag_full_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_rise && (bit_cnt == FULL)) |=> !short_word);
    p_flag_short_r6: assert property (@(posedge clk) disable iff (rst)
        (ld_rise && (bit_cnt != FULL)) |=> short_word);

    // R6: load edge captures the first rank
    p_capture_r6: assert property (@(posedge clk) disable iff (rst)
        ld_rise |=> dac_code == $past(rank1_q));

    // R7: counter never passes a full word and clears on frame or load edge
    p_cnt_bound_r7: assert property (@(posedge clk) disable iff (rst)
        bit_cnt <= FULL);
    p_cnt_clear_r7: assert property (@(posedge clk) disable iff (rst)
        ((ld_rise || fr_rise) && !bit_rise) |=> bit_cnt == '0);

endmodule

bind sdac_input_reg sdac_input_reg_chk #(.W(WORD_W), .CW(CW)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .bit_rise   (bit_rise),
    .bit_val    (pins_s.data),
    .ld_rise    (ld_rise),
    .fr_rise    (fr_rise),
    .ld_lvl     (pins_s.load),
    .hold_lvl   (pins_s.frame),
    .shift_q    (shift_q),
    .rank1_q    (rank1_q),
    .bit_cnt    (bit_cnt),
    .dac_code   (dac_code),
    .short_word (short_word)
);

// File: tb/sdac_input_reg_tb.sv
`timescale 1ns/1ps
module sdac_input_reg_tb_top;

    localparam int W = 16;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         ser_data = 1'b0;
    logic         cs_bclk = 1'b0;
    logic         frame_hold = 1'b0;
    logic         load_in = 1'b0;
    logic [W-1:0] dac_code;
    logic         short_word;

    int n_checks = 0;
    int n_fails  = 0;

    // bench-side model
    logic [W-1:0] m_sr = '0;
    logic [W-1:0] m_r1 = '0;
    logic [W-1:0] m_code = '0;
    int           m_cnt = 0;
    logic         m_short = 1'b0;
    logic         m_ld = 1'b0;
    logic         m_fh = 1'b0;

    always #4 clk = ~clk;

    sdac_input_reg dut_i (
        .clk        (clk),
        .rst        (rst),
        .ser_data   (ser_data),
        .cs_bclk    (cs_bclk),
        .frame_hold (frame_hold),
        .load_in    (load_in),
        .dac_code   (dac_code),
        .short_word (short_word)
    );

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_bit(input logic b);
        ser_data = b;
        wait_n(4);
        cs_bclk = 1'b1;
        wait_n(4);
        cs_bclk = 1'b0;
        wait_n(4);
        m_sr = {m_sr[W-2:0], b};
        if (!m_fh) m_r1 = m_sr;
        if (!m_ld) m_code = m_r1;
        if (m_cnt < W) m_cnt++;
    endtask

    task automatic send_bits(input logic [W-1:0] w, input int n);
        for (int i = n - 1; i >= 0; i--) send_bit(w[i]);
    endtask

    task automatic set_load(input logic v);
        load_in = v;
        wait_n(8);
        if (v && !m_ld) begin
            m_code  = m_r1;
            m_short = (m_cnt != W);
            m_cnt   = 0;
        end
        m_ld = v;
        if (!m_ld) m_code = m_r1;
    endtask

    task automatic set_frame(input logic v);
        frame_hold = v;
        wait_n(8);
        if (v && !m_fh) m_cnt = 0;
        m_fh = v;
        if (!m_fh) m_r1 = m_sr;
        if (!m_ld) m_code = m_r1;
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin : main
        logic [W-1:0] words [20];
        wait_n(5);
        rst = 1'b0;
        wait_n(6);
        chk(dac_code, '0, "R1 code after reset");
        chk({15'd0, short_word}, '0, "R1 flag after reset");

        for (int k = 0; k < W; k++) words[k] = W'(1) << k;
        words[16] = 16'hA5C3;
        words[17] = 16'hFFFF;
        words[18] = 16'h0000;
        words[19] = 16'h8001;

        // Full words, load low while shifting, then latch and disturb
        for (int k = 0; k < 20; k++) begin
            set_load(1'b0);
            send_bits(words[k], W);
            chk(dac_code, m_code, "R4 follows first rank while load low");
            set_load(1'b1);
            chk(dac_code, words[k], "R2 MSB-first word latched");
            chk({15'd0, short_word}, {15'd0, m_short}, "R6 full-word flag");
            chk({15'd0, short_word}, '0, "R6 full word gives zero flag");
            send_bits(~words[k], W);
            chk(dac_code, words[k], "R5 output frozen while load high");
        end
        set_load(1'b0);
        chk(dac_code, ~words[19], "R4 load low releases output");

        // Short word: clear count, then only 8 bits
        set_load(1'b1);
        set_load(1'b0);
        send_bits(16'h003C, 8);
        set_load(1'b1);
        chk({15'd0, short_word}, 16'd1, "R6 short word flag");
        chk(dac_code, m_code, "R6 short word captures first rank");
        chk(dac_code, {~words[19][7:0], 8'h3C}, "R6 short word value");

        // Count cleared at load edge: 8 more bits still short (R7)
        set_load(1'b0);
        send_bits(16'h00C3, 8);
        set_load(1'b1);
        chk({15'd0, short_word}, 16'd1, "R7 count cleared on load edge");
        chk(dac_code, 16'h3CC3, "R2 bytes combine MSB first");

        // Frame hold: first rank frozen while new bits shift
        set_load(1'b0);
        set_frame(1'b1);
        send_bits(16'h1234, W);
        chk(dac_code, 16'h3CC3, "R3 first rank held");
        set_frame(1'b0);
        chk(dac_code, 16'h1234, "R3 release takes whole shifter");

        // Frame rise clears count: 10 stale bits then held full word
        send_bits(16'h02AA, 10);
        set_frame(1'b1);
        send_bits(16'hBEEF, W);
        set_frame(1'b0);
        set_load(1'b1);
        chk({15'd0, short_word}, '0, "R7 frame edge restarts count");
        chk(dac_code, 16'hBEEF, "R3 held word latched");

        // Frame rise after 10 bits then only 6: short (R7)
        set_load(1'b0);
        send_bits(16'h0155, 10);
        set_frame(1'b1);
        send_bits(16'h0015, 6);
        set_frame(1'b0);
        set_load(1'b1);
        chk({15'd0, short_word}, 16'd1, "R7 bits before frame edge not counted");
        chk(dac_code, m_code, "R3 model match after hold");

        // Saturation: 20 bits still a full word
        set_load(1'b0);
        send_bits(16'h000F, 4);
        send_bits(16'hC0DE, W);
        set_load(1'b1);
        chk({15'd0, short_word}, '0, "R7 count saturates at 16");
        chk(dac_code, 16'hC0DE, "R2 last 16 bits kept");

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule